// File: doc/BRIEF.md
# Counting Phase Comparator with Lock Window

This block is the digital phase loop of a motor speed controller. The tachometer pulse train is first divided by two. The phase of the result is then compared with a reference pulse train. Both inputs are sampled on the speed-control clock. The comparator counts the cycles between the two rising edges. The direction of the error comes from which edge arrived first. The count becomes a trigger pulse: "accelerate" when the tachometer lags, "decelerate" when it leads. Downstream, an integrating amplifier turns these pulses into a motor drive level.

Two guards qualify the output. The first is a lock window. Each period of the halved tachometer signal is measured and checked against a nominal period with a tolerance of about ±6 %. Outside this window the phase error counts as zero, and lock is granted only after a run of good periods. The second is a reference watchdog. It switches the output off when the reference stops, and switches it back on after the reference has shown two fresh edges.

Both inputs are assumed to be already synchronous to `clk_i`. The nominal period is a static configuration value, given in clock cycles for one period of the halved tachometer signal, which equals one reference period.

Top module: `fg_phase_cmp`

## Requirements
- R1: The tachometer input is halved before comparison. Of its rising edges after reset, the 1st, 3rd, 5th and so on are the ones compared with the reference.
- R2: When a reference rising edge comes d > 0 cycles before the next compared tachometer edge (lagging phase), `trig_o` shows 2'b01 (accelerate) for w consecutive cycles.
- R3: When a compared tachometer edge comes d > 0 cycles before the next reference rising edge (leading phase), `trig_o` shows 2'b10 (decelerate) for w consecutive cycles.
- R4: The width is w = min(d, floor(nom/2)). Coincident edges (d = 0) produce no pulse.
- R5: `trig_o` is 2'b00 when idle, including after reset. The value 2'b11 never appears.
- R6: The period P of the halved tachometer signal is in the window when nom − s ≤ P ≤ nom + s, where s = floor(nom·61/1024). After a period outside the window, no new trigger pulse starts.
- R7: `lock_o` rises in the cycle after the 8th consecutive in-window period ends. It falls in the cycle after any out-of-window period ends. It is 0 after reset.
- R8: When no reference rising edge arrives for more than 4·nom cycles, `oe_o` drops to 0, two cycles after the count 4·nom is reached. While `oe_o` is 0, `trig_o` stays 2'b00.
- R9: `oe_o` is 0 after reset. It rises in the cycle after the second reference rising edge that follows reset or a loss of the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Speed-control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fg_i | input | 1 | Tachometer pulse input, synchronous |
| fref_i | input | 1 | Reference pulse input, synchronous |
| nom_period_i | input | CNT_W | Nominal period of halved tachometer and reference, in cycles |
| trig_o | output | 2 | Trigger code: 00 none, 01 accelerate, 10 decelerate |
| oe_o | output | 1 | Output enable, low while the reference is absent |
| lock_o | output | 1 | Frequency in lock window for 8 or more consecutive periods |

## Verification
The hardest states to reach from the ports are the exact edges of the qualification logic. These are the single period that breaks an established lock, and the watchdog boundary where the reference has just gone silent. The bench drives both pulse trains from arithmetic schedules. The tachometer schedule can switch its period in the middle of a run, so one out-of-window period can follow a held lock. The reference schedule can stop and restart on its grid. Every boundary cycle is then computed from the schedule and checked one cycle before and one cycle after the expected change. The bench also sweeps the phase offset across the clip point in both directions, and sweeps the tachometer period through both window edges.

// File: rtl/fg_phase_cmp_pkg.sv
package fg_phase_cmp_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_ACC  = 2'b01,
    TRIG_DEC  = 2'b10
  } trig_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REF_LEAD,
    PH_FG_LEAD
  } ph_state_e;
endpackage

// File: rtl/fg_phase_cmp_edge.sv
module fg_phase_cmp_edge #(
  parameter bit DIV2 = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  logic raw_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign raw_rise = sig_i & ~sig_q;

  generate
    if (DIV2) begin : g_div2
      logic tog_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       tog_q <= 1'b0;
        else if (raw_rise) tog_q <= ~tog_q;
      end
      // first edge after reset passes, every second one after
      assign rise_o = raw_rise & ~tog_q;
    end else begin : g_pass
      assign rise_o = raw_rise;
    end
  endgenerate
endmodule

// File: rtl/fg_phase_cmp_window.sv
module fg_phase_cmp_window #(
  parameter int CNT_W     = 16,
  parameter int LOCK_N    = 8,
  parameter int WIN_NUM   = 61,
  parameter int WIN_SHIFT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] nom_i,
  output logic             eval_o,
  output logic             in_win_o,
  output logic             win_q_o,
  output logic             lock_o
);
  localparam int MW = CNT_W + $clog2(WIN_NUM + 1);
  localparam int SW = $clog2(LOCK_N + 1);

  logic [CNT_W-1:0] per_q;
  logic             have_q;
  logic [SW-1:0]    streak_q;
  logic [CNT_W-1:0] slack;
  logic [CNT_W-1:0] lo;
  logic [CNT_W:0]   hi;

  assign slack    = CNT_W'((MW'(nom_i) * MW'(WIN_NUM)) >> WIN_SHIFT);
  assign lo       = nom_i - slack;
  assign hi       = {1'b0, nom_i} + {1'b0, slack};
  assign in_win_o = (per_q >= lo) && ({1'b0, per_q} <= hi);
  assign eval_o   = rise_i & have_q;
  assign lock_o   = (streak_q == SW'(LOCK_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q    <= '0;
      have_q   <= 1'b0;
      win_q_o  <= 1'b0;
      streak_q <= '0;
    end else begin
      if (rise_i) begin
        per_q  <= CNT_W'(1);
        have_q <= 1'b1;
      end else if (per_q != '1) begin
        per_q  <= per_q + 1'b1;
      end
      if (eval_o) begin
        win_q_o <= in_win_o;
        if (!in_win_o)                 streak_q <= '0;
        else if (streak_q != SW'(LOCK_N)) streak_q <= streak_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fg_phase_cmp_refwd.sv
module fg_phase_cmp_refwd #(
  parameter int CNT_W    = 16,
  parameter int TMO_MULT = 4,
  parameter int REARM_N  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] nom_i,
  output logic             oe_o
);
  localparam int TW = CNT_W + $clog2(TMO_MULT) + 1;
  localparam int RW = $clog2(REARM_N + 1);

  logic [TW-1:0] timer_q;
  logic [TW-1:0] lim;
  logic [RW-1:0] seen_q;

  assign lim  = TW'(nom_i) * TW'(TMO_MULT);
  assign oe_o = (seen_q == RW'(REARM_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      seen_q  <= '0;
    end else if (rise_i) begin
      timer_q <= '0;
      if (seen_q != RW'(REARM_N)) seen_q <= seen_q + 1'b1;
    end else begin
      if (timer_q < lim) timer_q <= timer_q + 1'b1;
      else               seen_q  <= '0;
    end
  end
endmodule

// File: rtl/fg_phase_cmp_phase.sv
module fg_phase_cmp_phase
  import fg_phase_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_rise_i,
  input  logic             fg_rise_i,
  input  logic             en_i,
  input  logic             oe_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             load_o,
  output logic [1:0]       trig_o
);
  ph_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pcnt_q;
  trig_e            pcode_q;
  logic             done;
  logic [CNT_W-1:0] meas;
  logic [CNT_W-1:0] width;
  trig_e            code;

  always_comb begin
    done = 1'b0;
    meas = '0;
    code = TRIG_NONE;
    unique case (state_q)
      PH_IDLE:     done = ref_rise_i & fg_rise_i;
      PH_REF_LEAD: if (fg_rise_i)  begin done = 1'b1; meas = cnt_q; code = TRIG_ACC; end
      PH_FG_LEAD:  if (ref_rise_i) begin done = 1'b1; meas = cnt_q; code = TRIG_DEC; end
      default: ;
    endcase
  end

  assign width  = (meas > half_i) ? half_i : meas;
  assign load_o = done & en_i & (width != '0);
  assign trig_o = (pcnt_q != '0 && oe_i) ? pcode_q : TRIG_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          if (ref_rise_i && !fg_rise_i) begin state_q <= PH_REF_LEAD; cnt_q <= CNT_W'(1); end
          else if (fg_rise_i && !ref_rise_i) begin state_q <= PH_FG_LEAD; cnt_q <= CNT_W'(1); end
        end
        PH_REF_LEAD: begin
          if (fg_rise_i)       state_q <= PH_IDLE;
          else if (ref_rise_i) cnt_q   <= CNT_W'(1);
          else if (cnt_q != '1) cnt_q  <= cnt_q + 1'b1;
        end
        PH_FG_LEAD: begin
          if (ref_rise_i)      state_q <= PH_IDLE;
          else if (fg_rise_i)  cnt_q   <= CNT_W'(1);
          else if (cnt_q != '1) cnt_q  <= cnt_q + 1'b1;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q  <= '0;
      pcode_q <= TRIG_NONE;
    end else if (load_o) begin
      pcnt_q  <= width;
      pcode_q <= code;
    end else if (pcnt_q != '0) begin
      pcnt_q  <= pcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fg_phase_cmp.sv
module fg_phase_cmp #(
  parameter int CNT_W     = 16,
  parameter int LOCK_N    = 8,
  parameter int TMO_MULT  = 4,
  parameter int REARM_N   = 2,
  parameter int WIN_NUM   = 61,
  parameter int WIN_SHIFT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fg_i,
  input  logic             fref_i,
  input  logic [CNT_W-1:0] nom_period_i,
  output logic [1:0]       trig_o,
  output logic             oe_o,
  output logic             lock_o
);
  logic ref_rise;
  logic fgh_rise;
  logic eval_stb;
  logic in_win;
  logic win_q;
  logic pulse_load;

  fg_phase_cmp_edge #(.DIV2(1'b0)) u_ref_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(fref_i), .rise_o(ref_rise)
  );

  fg_phase_cmp_edge #(.DIV2(1'b1)) u_fg_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(fg_i), .rise_o(fgh_rise)
  );

  fg_phase_cmp_window #(
    .CNT_W(CNT_W), .LOCK_N(LOCK_N), .WIN_NUM(WIN_NUM), .WIN_SHIFT(WIN_SHIFT)
  ) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(fgh_rise), .nom_i(nom_period_i),
    .eval_o(eval_stb), .in_win_o(in_win), .win_q_o(win_q), .lock_o(lock_o)
  );

  fg_phase_cmp_refwd #(
    .CNT_W(CNT_W), .TMO_MULT(TMO_MULT), .REARM_N(REARM_N)
  ) u_refwd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(ref_rise), .nom_i(nom_period_i),
    .oe_o(oe_o)
  );

  fg_phase_cmp_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_rise_i(ref_rise), .fg_rise_i(fgh_rise),
    .en_i(win_q & oe_o), .oe_i(oe_o), .half_i(nom_period_i >> 1),
    .load_o(pulse_load), .trig_o(trig_o)
  );
endmodule

// File: rtl/fg_phase_cmp_chk.sv
module fg_phase_cmp_chk #(
  parameter int CNT_W    = 16,
  parameter int LOCK_N   = 8,
  parameter int TMO_MULT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       trig_i,
  input logic             oe_i,
  input logic             lock_i,
  input logic [CNT_W-1:0] nom_i,
  input logic             ref_rise_i,
  input logic             eval_i,
  input logic             in_win_i,
  input logic             load_i
);
  localparam int GW = CNT_W + $clog2(TMO_MULT) + 3;
  localparam int SW = $clog2(LOCK_N + 1) + 1;

  logic [GW-1:0]    gap_q;
  logic [CNT_W-1:0] run_q;
  logic [SW-1:0]    good_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      run_q  <= '0;
      good_q <= '0;
    end else begin
      if (ref_rise_i)      gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (load_i)                          run_q <= '0;
      else if (trig_i != 2'b00 && run_q != '1) run_q <= run_q + 1'b1;
      if (eval_i) begin
        if (!in_win_i)         good_q <= '0;
        else if (good_q != '1) good_q <= good_q + 1'b1;
      end
    end
  end

  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i != 2'b11); // R5

  AST_WIDTH_CLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= (nom_i >> 1)); // R4

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> trig_i == 2'b00); // R8

  AST_REF_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q > GW'(nom_i) * GW'(TMO_MULT)) |-> !oe_i); // R8

  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !in_win_i) |=> !lock_i); // R7

  AST_LOCK_EARNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> good_q >= SW'(LOCK_N)); // R7
endmodule

bind fg_phase_cmp fg_phase_cmp_chk #(
  .CNT_W(CNT_W), .LOCK_N(LOCK_N), .TMO_MULT(TMO_MULT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_o), .oe_i(oe_o), .lock_i(lock_o),
  .nom_i(nom_period_i), .ref_rise_i(ref_rise), .eval_i(eval_stb),
  .in_win_i(in_win), .load_i(pulse_load)
);

// File: tb/sim_fg_phase_cmp.sv
module sim_fg_phase_cmp;
  localparam int NOM = 100;
  localparam int HN  = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fg = 1'b0;
  logic        fref = 1'b0;
  logic [15:0] nom = 16'(NOM);
  logic [1:0]  trig;
  logic        oe;
  logic        lock;

  int checks = 0;
  int errors = 0;

  logic [1:0] trig_h [HN];
  logic       oe_h   [HN];
  logic       lock_h [HN];

  always #2 clk = ~clk;

  fg_phase_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .fg_i(fg), .fref_i(fref),
    .nom_period_i(nom), .trig_o(trig), .oe_o(oe), .lock_o(lock)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fg = 1'b0; fref = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic bit fg_at(int t, int f0, int p, int psw, int p2);
    int u, pp, j;
    if (t < f0) return 1'b0;
    u = t - f0; pp = p;
    if (psw > 0 && u >= psw * p) begin u = u - psw * p; pp = p2; end
    j = (2 * u + pp - 1) / pp;
    return (j * pp < 2 * u + 2);
  endfunction

  function automatic bit ref_at(int t, int r0, int rstop, int rstart2);
    if (t < r0) return 1'b0;
    if (t >= rstop && t < rstart2) return 1'b0;
    return ((t - r0) % NOM) == 0;
  endfunction

  task automatic run(input int n, input int r0, input int rstop, input int rstart2,
                     input int f0, input int p, input int psw, input int p2);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      trig_h[t] = trig; oe_h[t] = oe; lock_h[t] = lock;
      fref = ref_at(t, r0, rstop, rstart2);
      fg   = fg_at(t, f0, p, psw, p2);
    end
    @(negedge clk);
    fref = 1'b0; fg = 1'b0;
  endtask

  function automatic int cnt_code(logic [1:0] code, int a, int b);
    int c = 0;
    for (int t = a; t < b; t++) if (trig_h[t] == code) c++;
    return c;
  endfunction

  task automatic phase_case(input int d, input bit lag);
    int r0, f0, mx, w, n, t0, acc, dec, eacc, edec;
    r0 = lag ? 10 : 10 + d;
    f0 = lag ? 10 + d : 10;
    mx = (r0 > f0) ? r0 : f0;
    w  = (d < NOM / 2) ? d : NOM / 2;
    n  = mx + 16 * NOM + 5;
    do_reset();
    @(negedge clk);
    check(trig == 2'b00 && !oe && !lock, "R5 reset state", {trig, oe, lock}, 0);
    run(n, r0, 1 << 30, 1 << 30, f0, NOM, 0, NOM);
    t0 = mx + 12 * NOM;
    acc = cnt_code(2'b01, t0, t0 + 4 * NOM);
    dec = cnt_code(2'b10, t0, t0 + 4 * NOM);
    eacc = (lag && d > 0) ? 4 * w : 0;
    edec = (!lag && d > 0) ? 4 * w : 0;
    check(acc == eacc, lag ? "R1 R2 R4 accelerate cycles" : "R3 accelerate absent", acc, eacc);
    check(dec == edec, lag ? "R2 decelerate absent" : "R1 R3 R4 decelerate cycles", dec, edec);
    check(cnt_code(2'b11, 0, n) == 0, "R5 illegal code", cnt_code(2'b11, 0, n), 0);
    check(oe_h[r0 + NOM] == 1'b0, "R9 oe before second edge", oe_h[r0 + NOM], 0);
    check(oe_h[r0 + NOM + 1] == 1'b1, "R9 oe after second edge", oe_h[r0 + NOM + 1], 1);
    check(lock_h[f0 + 8 * NOM] == 1'b0, "R7 lock before 8th period", lock_h[f0 + 8 * NOM], 0);
    check(lock_h[f0 + 8 * NOM + 1] == 1'b1, "R7 lock after 8th period", lock_h[f0 + 8 * NOM + 1], 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ds [8] = '{1, 2, 7, 49, 50, 51, 80, 99};
    int slack;
    slack = (NOM * 61) / 1024;

    // R2 R3 R4: phase sweep in both directions, across the clip point
    phase_case(0, 1'b1);
    foreach (ds[i]) phase_case(ds[i], 1'b1);
    foreach (ds[i]) phase_case(ds[i], 1'b0);

    // R6 R7: window sweep over the halved-FG period
    for (int p = NOM - 10; p <= NOM + 10; p++) begin
      int n;
      bit inw;
      n   = 10 + 13 * p + 5;
      inw = (p >= NOM - slack) && (p <= NOM + slack);
      do_reset();
      run(n, 10, 1 << 30, 1 << 30, 10, p, 0, p);
      check(lock_h[n - 1] == inw, "R6 R7 lock versus window", lock_h[n - 1], inw);
      if (!inw)
        check(cnt_code(2'b00, 0, n) == n, "R6 no trigger out of window",
              n - cnt_code(2'b00, 0, n), 0);
    end

    // R7 R6: one out-of-window period breaks a held lock
    do_reset();
    run(1700, 10, 1 << 30, 1 << 30, 10, NOM, 10, NOM + 20);
    check(lock_h[1130] == 1'b1, "R7 lock held before bad period", lock_h[1130], 1);
    check(lock_h[1131] == 1'b0, "R7 lock cleared after bad period", lock_h[1131], 0);
    check(cnt_code(2'b00, 1160, 1700) == 540, "R6 no trigger after bad period",
          540 - cnt_code(2'b00, 1160, 1700), 0);

    // R8 R9: reference lost after edge 910, back on grid at 2010
    do_reset();
    run(2300, 10, 1000, 2000, 30, NOM, 0, NOM);
    check(oe_h[910 + 4 * NOM + 1] == 1'b1, "R8 oe at timeout limit", oe_h[910 + 4 * NOM + 1], 1);
    check(oe_h[910 + 4 * NOM + 2] == 1'b0, "R8 oe dropped after timeout", oe_h[910 + 4 * NOM + 2], 0);
    check(cnt_code(2'b00, 1312, 2111) == 799, "R8 trigger off while reference absent",
          799 - cnt_code(2'b00, 1312, 2111), 0);
    check(oe_h[2110] == 1'b0, "R9 oe after one new edge", oe_h[2110], 0);
    check(oe_h[2111] == 1'b1, "R9 oe after two new edges", oe_h[2111], 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule